// File: doc/BRIEF.md
# Folding CRC-32 Accumulator

This block takes a message as a stream of 128-bit words and reduces it to one 128-bit residue. The residue is congruent to the message modulo the CRC-32 generator 0x04C11DB7, with bits taken most-significant first. It never runs a serial or table-driven CRC update. It keeps four 128-bit lanes. Each lane absorbs every fourth word through a carry-less multiply by a constant that represents a distance of four words. When the stream ends, the lanes are merged into one. Any words after the last complete 64-byte group are folded into that single lane using a one-word distance constant.

A caller pulses `start_i` with the initial CRC value and then streams the words with a valid/ready handshake, marking the final word. The message must be a whole number of 16-byte words and at least 64 bytes long. When `done_o` pulses, `residue_o` holds the 128-bit remainder candidate. A later stage reduces it to the 32-bit CRC by computing the residue times x^32 modulo the generator.

Top module: `crc_fold_acc`

## Requirements
- R1: After reset, `ready_o` and `done_o` are low. A `start_i` pulse while idle captures `crc_init_i`, and `ready_o` is high from the next cycle.
- R2: Within a word, stream byte 0 sits at bits 127:120. The initial CRC is XORed into bits 127:96 of the first word of the message.
- R3: When the message length is a multiple of 64 bytes, reducing `residue_o` (residue times x^32 mod 0x104C11DB7) gives the MSB-first CRC-32 of the message, with the given initial value and no final inversion.
- R4: Each complete 64-byte group after the first folds every lane once, using the constants 0x08833794C (upper half) and 0x0E6228B11 (lower half).
- R5: When 1 to 3 words follow the last complete group, the lanes are merged in order 2, 3, 4 into lane 1 with the constants 0x0C5B9CD4C and 0x0E8A45605. The trailing words are then folded into lane 1 with the same constants, and the reduced residue equals the message CRC.
- R6: From the cycle after the handshake of the last word, `ready_o` stays low. `done_o` rises 3 + t cycles after that handshake edge, where t is the count of trailing words (0 to 3).
- R7: A cycle with `valid_i` low consumes no word, and `residue_o` does not change in that cycle.
- R8: `done_o` is high for exactly one cycle. `residue_o` then stays stable while the block is idle.
- R9: `start_i` is ignored while a message is streaming or being merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message (honoured only when idle) |
| crc_init_i | input | 32 | Initial CRC value |
| valid_i | input | 1 | Word on `data_i` is valid |
| data_i | input | 128 | Message word, byte 0 in bits 127:120 |
| last_i | input | 1 | Marks the final word of the message |
| ready_o | output | 1 | Block accepts a word this cycle |
| residue_o | output | 128 | Folded 128-bit residue |
| done_o | output | 1 | One-cycle strobe: residue is final |

## Verification
The bench builds the block with its default values: four lanes of 128 bits and 33-bit fold constants. With those values, every trailing-word count from zero to three is reachable, as are single-group messages and messages with many groups. Random lengths from 4 to 40 words cover each merge-and-tail path many times. Valid gaps and stray start pulses land both in the middle of a group and at group boundaries.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;
  localparam int CRC_W = 32;
  // x^576, x^512, x^192, x^128 mod P (33-bit form)
  localparam logic [CRC_W:0] K_FAR_HI  = 33'h08833794C;
  localparam logic [CRC_W:0] K_FAR_LO  = 33'h0E6228B11;
  localparam logic [CRC_W:0] K_NEAR_HI = 33'h0C5B9CD4C;
  localparam logic [CRC_W:0] K_NEAR_LO = 33'h0E8A45605;

  typedef enum logic [1:0] {ST_IDLE, ST_STREAM, ST_MERGE, ST_TAIL} fold_st_e;
endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
  parameter int AW = 64,
  parameter int BW = 33
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-2:0] p_o
);
  always_comb begin
    p_o = '0;
    for (int i = 0; i < BW; i++) begin
      if (b_i[i]) p_o = p_o ^ ({{(BW-1){1'b0}}, a_i} << i);
    end
  end
endmodule

// File: rtl/crc_fold_step.sv
module crc_fold_step #(
  parameter int W  = 128,
  parameter int KW = 33
) (
  input  logic [W-1:0]  v_i,
  input  logic [KW-1:0] k_hi_i,
  input  logic [KW-1:0] k_lo_i,
  input  logic [W-1:0]  add_i,
  output logic [W-1:0]  y_o
);
  localparam int HW = W / 2;
  localparam int PW = HW + KW - 1;

  logic [PW-1:0] p_hi, p_lo;

  crc_clmul #(.AW(HW), .BW(KW)) u_hi (.a_i(v_i[W-1:HW]), .b_i(k_hi_i), .p_o(p_hi));
  crc_clmul #(.AW(HW), .BW(KW)) u_lo (.a_i(v_i[HW-1:0]), .b_i(k_lo_i), .p_o(p_lo));

  assign y_o = {{(W-PW){1'b0}}, p_hi ^ p_lo} ^ add_i;
endmodule

// File: rtl/crc_fold_acc.sv
module crc_fold_acc
  import crc_fold_pkg::*;
#(
  parameter int W     = 128,
  parameter int LANES = 4,
  parameter logic [CRC_W:0] K_R1 = K_FAR_HI,
  parameter logic [CRC_W:0] K_R2 = K_FAR_LO,
  parameter logic [CRC_W:0] K_R3 = K_NEAR_HI,
  parameter logic [CRC_W:0] K_R4 = K_NEAR_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CRC_W-1:0] crc_init_i,
  input  logic             valid_i,
  input  logic [W-1:0]     data_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic [W-1:0]     residue_o,
  output logic             done_o
);
  localparam int CW = $clog2(LANES);
  localparam logic [CW-1:0] LAST_POS = CW'(LANES - 1);

  fold_st_e         st_q;
  logic [CW-1:0]    pos_q, mi_q, ti_q, tcnt_q;
  logic             first_q, done_q;
  logic [CRC_W-1:0] crc_q;
  logic [W-1:0]     lane_q  [LANES];
  logic [W-1:0]     buf_q   [LANES];
  logic [W-1:0]     chunk_w [LANES];
  logic [W-1:0]     wide_y  [LANES];
  logic [W-1:0]     nar_add, nar_y, init_w;
  logic             fire;

  assign ready_o   = (st_q == ST_STREAM);
  assign fire      = valid_i && ready_o;
  assign residue_o = lane_q[0];
  assign done_o    = done_q;
  assign init_w    = {crc_q, {(W-CRC_W){1'b0}}};

  // one wide fold per lane, applied when a group completes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == LANES - 1) begin : g_in
      assign chunk_w[g] = data_i;
    end else begin : g_buf
      assign chunk_w[g] = buf_q[g];
    end
    crc_fold_step #(.W(W), .KW(CRC_W+1)) u_wide (
      .v_i(lane_q[g]), .k_hi_i(K_R1), .k_lo_i(K_R2),
      .add_i(chunk_w[g]), .y_o(wide_y[g]));
  end

  assign nar_add = (st_q == ST_MERGE) ? lane_q[mi_q] : buf_q[ti_q];

  crc_fold_step #(.W(W), .KW(CRC_W+1)) u_near (
    .v_i(lane_q[0]), .k_hi_i(K_R3), .k_lo_i(K_R4),
    .add_i(nar_add), .y_o(nar_y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      mi_q    <= '0;
      ti_q    <= '0;
      tcnt_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      crc_q   <= '0;
      for (int g = 0; g < LANES; g++) begin
        lane_q[g] <= '0;
        buf_q[g]  <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          crc_q   <= crc_init_i;
          pos_q   <= '0;
          first_q <= 1'b1;
          st_q    <= ST_STREAM;
        end
        ST_STREAM: if (fire) begin
          if (pos_q == LAST_POS) begin
            for (int g = 0; g < LANES; g++)
              lane_q[g] <= first_q ? (chunk_w[g] ^ ((g == 0) ? init_w : '0)) : wide_y[g];
            first_q <= 1'b0;
            pos_q   <= '0;
            tcnt_q  <= '0;
          end else begin
            for (int g = 0; g < LANES; g++)
              if (pos_q == CW'(g)) buf_q[g] <= data_i;
            pos_q  <= pos_q + CW'(1);
            tcnt_q <= pos_q + CW'(1);
          end
          if (last_i) begin
            mi_q <= CW'(1);
            st_q <= ST_MERGE;
          end
        end
        ST_MERGE: begin
          lane_q[0] <= nar_y;
          if (mi_q == LAST_POS) begin
            ti_q <= '0;
            if (tcnt_q == '0) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_TAIL;
            end
          end else begin
            mi_q <= mi_q + CW'(1);
          end
        end
        ST_TAIL: begin
          lane_q[0] <= nar_y;
          if (ti_q == tcnt_q - CW'(1)) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            ti_q <= ti_q + CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i) |=> ready_o);
  // R6
  last_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && last_i) |=> !ready_o);
  // R6
  done_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
  // R7
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> $stable(residue_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(residue_o));
endmodule

// File: tb/sim_crc_fold_acc.sv
module sim_crc_fold_acc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  crc_init = '0;
  logic         valid = 1'b0;
  logic [127:0] data = '0;
  logic         last = 1'b0;
  logic         ready, done;
  logic [127:0] residue;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  crc_fold_acc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .crc_init_i(crc_init),
    .valid_i(valid), .data_i(data), .last_i(last),
    .ready_o(ready), .residue_o(residue), .done_o(done));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[31] ^ b;
    c  = {c[30:0], 1'b0};
    if (fb) c = c ^ 32'h04C11DB7;
    return c;
  endfunction

  // reduce residue: R * x^32 mod P
  function automatic logic [31:0] reduce(input logic [127:0] r);
    logic [31:0] c = '0;
    for (int i = 127; i >= 0; i--) c = crc_step(c, r[i]);
    return c;
  endfunction

  // nwords words, gap: insert valid-low cycles, poke: stray start mid-message
  task automatic run_msg(input int nwords, input logic [31:0] init, input bit zero,
                         input bit gap, input bit poke);
    logic [127:0] words[$];
    logic [31:0]  ref_crc;
    logic [127:0] held;
    int           t;
    ref_crc = init;
    for (int w = 0; w < nwords; w++) begin
      logic [127:0] v;
      v = zero ? '0 : {$urandom, $urandom, $urandom, $urandom};
      words.push_back(v);
      for (int by = 0; by < 16; by++)       // R2: byte 0 at 127:120
        for (int b = 7; b >= 0; b--)
          ref_crc = crc_step(ref_crc, v[127 - 8*by - (7 - b)]);
    end
    t = nwords % 4;
    @(negedge clk);
    start = 1'b1; crc_init = init;
    @(negedge clk);
    start = 1'b0;
    chk(ready === 1'b1, "R1 ready after start", {127'd0, ready}, 128'd1);
    for (int w = 0; w < nwords; w++) begin
      if (gap && (w % 3 == 1)) begin
        valid = 1'b0;
        @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0, "R7 gap keeps stream", {126'd0, ready, done}, 128'd2);
      end
      valid = 1'b1; data = words[w]; last = (w == nwords - 1);
      start = poke && (w == 2);
      @(negedge clk);
      start = 1'b0;
      if (w != nwords - 1)
        chk(ready === 1'b1, "R9 stream continues despite start", {127'd0, ready}, 128'd1);
    end
    valid = 1'b0; last = 1'b0;
    // last accepted at the edge before this negedge (k=1)
    for (int k = 1; k < 4 + t; k++) begin
      chk(ready === 1'b0 && done === 1'b0, "R6 busy after last", {126'd0, ready, done}, 128'd0);
      @(negedge clk);
    end
    chk(done === 1'b1, "R6 done latency", {127'd0, done}, 128'd1);
    if (t == 0)
      chk(reduce(residue) === ref_crc, "R3 residue reduces to CRC", {96'd0, reduce(residue)}, {96'd0, ref_crc});
    else
      chk(reduce(residue) === ref_crc, "R5 merge and tail CRC", {96'd0, reduce(residue)}, {96'd0, ref_crc});
    if (nwords >= 8 && t == 0)
      chk(reduce(residue) === ref_crc, "R4 multi-group fold", {96'd0, reduce(residue)}, {96'd0, ref_crc});
    if (zero && init == '0)
      chk(residue === '0, "R2 zero message residue", residue, '0);
    held = residue;
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", {127'd0, done}, 128'd0);
    @(negedge clk);
    chk(residue === held, "R8 residue held idle", residue, held);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready === 1'b0 && done === 1'b0, "R1 reset state", {126'd0, ready, done}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b0 && done === 1'b0, "R1 idle after reset", {126'd0, ready, done}, 128'd0);
    run_msg(4, 32'h0, 1'b1, 1'b0, 1'b0);         // R2 zero data
    run_msg(4, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);  // R2 init placement, R3
    run_msg(5, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);  // R5 t=1
    run_msg(6, 32'h12345678, 1'b0, 1'b0, 1'b0);  // R5 t=2
    run_msg(7, 32'hA5A5A5A5, 1'b0, 1'b1, 1'b0);  // R5 t=3, R7
    run_msg(8, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);  // R4
    run_msg(12, 32'h0, 1'b0, 1'b1, 1'b1);        // R4 R7 R9
    run_msg(9, 32'hDEADBEEF, 1'b0, 1'b0, 1'b1);  // R9 with tail
    for (int i = 0; i < 24; i++)
      run_msg(4 + $urandom_range(0, 36), $urandom, 1'b0, i[0], i[1]);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule